// File: doc/BRIEF.md
# SPI EEPROM slave interface

This block is the serial-peripheral slave front end of a small byte-addressed nonvolatile memory model. The master frames each transaction with an active-low select, shifts an 8-bit instruction in on SI, and then sends an address and data or reads data back on SO. All pin activity is oversampled by the system clock. The block has a status register with two block-protect bits, a write-enable latch, a busy flag and a protect-enable bit. A write-protect pin guards the protection fields. A pause input can suspend a transaction at any bit and resume it later.

Writes are staged while the frame is open. They are committed by a modelled internal write cycle, which begins when select returns high and lasts a fixed number of system clocks. During that cycle only status reads are served. High impedance on SO is shown by the output-enable signal `soEn`.

Top module: `spiee_slave`

## Requirements
- R1: SI is captured on each rising SCK edge while select is low. Bits arrive MSB first, and the first byte of a frame is the instruction.
- R2: SO changes only after falling SCK edges and is sent MSB first. Reads give the same data whether SCK idles low (mode 0) or high (mode 3).
- R3: While `csN` is high, `soEn` is 0 and `so` is 0. A falling `csN` restarts bit and byte counting, so a frame abandoned part-way leaves no trace.
- R4: The instruction codes are 0x06 (set write-enable), 0x04 (clear write-enable), 0x05 (read status, repeated for every further byte), 0x01 (write status, one data byte), 0x03 (read: address byte, then data with the address incrementing and wrapping at the array size) and 0x02 (write: address byte, then data; the last complete byte is written). Only the low ADDR_W bits of the address byte are used.
- R5: The status byte is {protect-enable, 3'b000, blockProtect[1:0], writeEnable, busy}, with bit 7 the MSB. It reads 0x00 after reset.
- R6: An array write or status write sent while the write-enable latch is 0 changes nothing and starts no write cycle.
- R7: A write cycle begins only when `csN` rises and lasts exactly WRITE_CYCLES clocks, with the busy bit at 1. New contents appear when the cycle ends, and the write-enable latch clears at that point.
- R8: While busy, every instruction except read status is ignored, including set write-enable.
- R9: Block protection covers none of the array for code 0, the top quarter for code 1, the top half for code 2 and all of it for code 3. A write into a protected address is discarded, starts no cycle and leaves the write-enable latch set.
- R10: When `wpN` is 0 and protect-enable is 1, a status write leaves both the block-protect bits and protect-enable unchanged.
- R11: While the pause is active, SCK and SI are ignored, `soEn` is 0, and the transaction resumes intact when the pause ends. `holdN` changes take effect only while SCK is low.
- R12: The clear write-enable instruction sets the write-enable latch to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low chip select framing each transaction |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data in |
| holdN | input | 1 | Active-low pause of the current transaction |
| wpN | input | 1 | Active-low write-protect pin |
| so | output | 1 | Serial data out (0 when not enabled) |
| soEn | output | 1 | Output enable for SO; 0 means high impedance |

## Verification
The bench builds the block with ADDR_W = 4 and WRITE_CYCLES = 600. A 16-byte array puts the quarter and half protection boundaries and the read wrap-around within reach of a handful of writes. A 600-clock write cycle is long enough for a status read, an ignored set-write-enable and an ignored write to all fall inside one busy window. The assertions count the busy window against WRITE_CYCLES, tie its start to the select rise, and check that paused or deselected periods keep SO disabled.

// File: rtl/spiee_pkg.sv
package spiee_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [1:0] {
    PEND_NONE,
    PEND_DATA,
    PEND_STAT
  } pend_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftRx;
    logic setWel;
    logic clrWel;
    logic capAddr;
    logic stageData;
    logic stageStat;
    logic loadStat;
    logic loadMem;
    logic shiftTx;
    logic finishData;
    logic finishStat;
  } strobes_t;

endpackage

// File: rtl/spiee_ctrl.sv
module spiee_ctrl
  import spiee_pkg::*;
#(
  parameter int WRITE_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sck,
  input  logic       holdN,
  input  logic [7:0] rxNext,
  input  logic       wel,
  input  logic       arrayBlocked,
  output strobes_t   strb,
  output logic       busy,
  output logic       soEn
);

  localparam int TW = $clog2(WRITE_CYCLES + 1);

  logic          sckQ, csQ, holdActive, holdNext;
  logic          live, sckRise, sckFall, csFall, csRise, byteDone;
  logic [2:0]    bitCnt;
  logic [1:0]    byteCnt;
  logic [7:0]    opcode;
  logic          ignore;
  pend_e         pend, kind;
  logic [TW-1:0] timer;
  logic          startWrite, lastTick;

  // pause state may change only while SCK is low
  assign holdNext = sck ? holdActive : ~holdN;

  assign live     = ~csN & ~csQ & ~holdActive;
  assign sckRise  = live & sck & ~sckQ;
  assign sckFall  = live & ~sck & sckQ;
  assign csFall   = csQ & ~csN;
  assign csRise   = ~csQ & csN;
  assign byteDone = sckRise && (bitCnt == 3'd7);
  assign lastTick = busy && (timer == TW'(1));

  assign startWrite = csRise && !busy && wel &&
                      ((pend == PEND_STAT) || (pend == PEND_DATA && !arrayBlocked));

  always_comb begin
    strb = '0;
    strb.shiftRx = sckRise;
    if (byteDone && !ignore) begin
      if (byteCnt == 2'd0) begin
        if (!busy) begin
          if (rxNext == OP_WREN) strb.setWel = 1'b1;
          if (rxNext == OP_WRDI) strb.clrWel = 1'b1;
        end
      end else if (byteCnt == 2'd1) begin
        if (opcode == OP_READ || opcode == OP_WRITE) strb.capAddr = 1'b1;
        if (opcode == OP_WRSR) strb.stageStat = 1'b1;
      end else if (opcode == OP_WRITE) begin
        strb.stageData = 1'b1;
      end
    end
    if (sckFall) begin
      if (!ignore && bitCnt == 3'd0 && opcode == OP_RDSR && byteCnt != 2'd0)
        strb.loadStat = 1'b1;
      else if (!ignore && bitCnt == 3'd0 && opcode == OP_READ && byteCnt >= 2'd2)
        strb.loadMem = 1'b1;
      else
        strb.shiftTx = 1'b1;
    end
    strb.finishData = lastTick && (kind == PEND_DATA);
    strb.finishStat = lastTick && (kind == PEND_STAT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckQ       <= 1'b0;
      csQ        <= 1'b1;
      holdActive <= 1'b0;
      soEn       <= 1'b0;
    end else begin
      sckQ       <= sck;
      csQ        <= csN;
      holdActive <= holdNext;
      soEn       <= ~csN & ~holdNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt  <= '0;
      byteCnt <= '0;
      opcode  <= '0;
      ignore  <= 1'b0;
      pend    <= PEND_NONE;
    end else if (csFall) begin
      bitCnt  <= '0;
      byteCnt <= '0;
      opcode  <= '0;
      ignore  <= 1'b0;
      pend    <= PEND_NONE;
    end else if (csRise) begin
      pend    <= PEND_NONE;
    end else if (sckRise) begin
      bitCnt <= bitCnt + 3'd1;
      if (bitCnt == 3'd7) begin
        if (byteCnt != 2'd3) byteCnt <= byteCnt + 2'd1;
        if (byteCnt == 2'd0) begin
          opcode <= rxNext;
          if (busy && rxNext != OP_RDSR) ignore <= 1'b1;
        end
      end
      if (strb.stageData) pend <= PEND_DATA;
      if (strb.stageStat) pend <= PEND_STAT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      timer <= '0;
      kind  <= PEND_NONE;
    end else if (startWrite) begin
      busy  <= 1'b1;
      timer <= TW'(WRITE_CYCLES);
      kind  <= pend;
    end else if (busy) begin
      timer <= timer - TW'(1);
      if (lastTick) begin
        busy <= 1'b0;
        kind <= PEND_NONE;
      end
    end
  end

endmodule

// File: rtl/spiee_datapath.sv
module spiee_datapath
  import spiee_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       si,
  input  logic       wpN,
  input  logic       busy,
  input  logic       soEn,
  input  strobes_t   strb,
  output logic [7:0] rxNext,
  output logic       so,
  output logic       wel,
  output logic       arrayBlocked,
  output logic [1:0] bpBits,
  output logic       wpenBit
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]        mem [DEPTH];
  logic [6:0]        rxShift;
  logic [7:0]        txShift;
  logic [ADDR_W-1:0] addrReg;
  logic [7:0]        pendData;
  logic [1:0]        pendBp;
  logic              pendWpen;
  logic [7:0]        statusByte;
  logic              hwProt;

  assign rxNext     = {rxShift, si};
  assign statusByte = {wpenBit, 3'b000, bpBits, wel, busy};
  assign hwProt     = ~wpN & wpenBit;
  assign so         = soEn & txShift[7];

  always_comb begin
    case (bpBits)
      2'd0:    arrayBlocked = 1'b0;
      2'd1:    arrayBlocked = &addrReg[ADDR_W-1 -: 2];
      2'd2:    arrayBlocked = addrReg[ADDR_W-1];
      default: arrayBlocked = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift  <= '0;
      txShift  <= '0;
      addrReg  <= '0;
      pendData <= '0;
      pendBp   <= '0;
      pendWpen <= 1'b0;
    end else begin
      if (strb.shiftRx)   rxShift  <= rxNext[6:0];
      if (strb.capAddr)   addrReg  <= rxNext[ADDR_W-1:0];
      if (strb.stageData) pendData <= rxNext;
      if (strb.stageStat) begin
        pendBp   <= rxNext[3:2];
        pendWpen <= rxNext[7];
      end
      if (strb.loadStat) begin
        txShift <= statusByte;
      end else if (strb.loadMem) begin
        txShift <= mem[addrReg];
        addrReg <= addrReg + ADDR_W'(1);
      end else if (strb.shiftTx) begin
        txShift <= {txShift[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wel     <= 1'b0;
      bpBits  <= '0;
      wpenBit <= 1'b0;
    end else begin
      if (strb.setWel) wel <= 1'b1;
      if (strb.clrWel || strb.finishData || strb.finishStat) wel <= 1'b0;
      if (strb.finishStat && !hwProt) begin
        bpBits  <= pendBp;
        wpenBit <= pendWpen;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strb.finishData) begin
      mem[addrReg] <= pendData;
    end
  end

endmodule

// File: rtl/spiee_slave.sv
module spiee_slave
  import spiee_pkg::*;
#(
  parameter int ADDR_W       = 7,
  parameter int WRITE_CYCLES = 5000
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic si,
  input  logic holdN,
  input  logic wpN,
  output logic so,
  output logic soEn
);

  strobes_t   strb;
  logic       busy, wel, arrayBlocked, wpenBit;
  logic [7:0] rxNext;
  logic [1:0] bpBits;

  spiee_ctrl #(
    .WRITE_CYCLES(WRITE_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .holdN(holdN),
    .rxNext(rxNext), .wel(wel), .arrayBlocked(arrayBlocked),
    .strb(strb), .busy(busy), .soEn(soEn)
  );

  spiee_datapath #(
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .si(si), .wpN(wpN), .busy(busy), .soEn(soEn),
    .strb(strb), .rxNext(rxNext), .so(so), .wel(wel),
    .arrayBlocked(arrayBlocked), .bpBits(bpBits), .wpenBit(wpenBit)
  );

endmodule

// File: rtl/spiee_slave_checker.sv
module spiee_slave_checker #(
  parameter int WRITE_CYCLES = 5000
) (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       sck,
  input logic       holdN,
  input logic       wpN,
  input logic       soEn,
  input logic       busy,
  input logic       wel,
  input logic [1:0] bpBits,
  input logic       wpenBit
);

  logic [31:0] busyLen;

  always_ff @(posedge clk) begin
    if (!rstN)     busyLen <= '0;
    else if (busy) busyLen <= busyLen + 32'd1;
    else           busyLen <= '0;
  end

  assert_standby_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN)) |-> !soEn);

  assert_hold_off_R11: assert property (@(posedge clk) disable iff (!rstN)
    $past(!holdN && !sck) |-> !soEn);

  assert_start_on_cs_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(csN) && !$past(csN, 2)));

  assert_cycle_length_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyLen == 32'(WRITE_CYCLES)));

  assert_wel_cleared_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !wel);

  assert_hw_protect_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!wpN && wpenBit) |=> ($stable(bpBits) && $stable(wpenBit)));

endmodule

bind spiee_slave spiee_slave_checker #(
  .WRITE_CYCLES(WRITE_CYCLES)
) u_check (
  .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .holdN(holdN), .wpN(wpN),
  .soEn(soEn), .busy(busy), .wel(wel), .bpBits(bpBits), .wpenBit(wpenBit)
);

// File: tb/spiee_slave_bench.sv
`timescale 1ns/1ps
module spiee_slave_bench;

  localparam int AW = 4;
  localparam int WC = 600;
  localparam int NV = 6;
  // {address, data}: write then read back
  localparam logic [15:0] VEC [NV] = '{16'h003C, 16'h01A5, 16'h0F81,
                                       16'h08FF, 16'h04C3, 16'h0A5A};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sck = 1'b0, si = 1'b0, holdN = 1'b1, wpN = 1'b1;
  logic so, soEn;
  logic mode3 = 1'b0;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  spiee_slave #(.ADDR_W(AW), .WRITE_CYCLES(WC)) u_spiee_slave (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si),
    .holdN(holdN), .wpN(wpN), .so(so), .soEn(soEn)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xferBit(input logic b, output logic r);
    sck = 1'b0; si = b;
    waitClk(4);
    r = so;
    sck = 1'b1;
    waitClk(4);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) xferBit(tx[i], rx[i]);
  endtask

  task automatic csLow();
    sck = mode3; waitClk(2);
    csN = 1'b0; waitClk(4);
  endtask

  task automatic csHigh();
    if (!mode3) sck = 1'b0;
    waitClk(4);
    csN = 1'b1; waitClk(4);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] r;
    csLow(); xfer(op, r); csHigh();
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] r;
    csLow(); xfer(8'h05, r); xfer(8'h00, st); csHigh();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    csLow(); xfer(8'h01, r); xfer(v, r); csHigh();
  endtask

  task automatic wrByte(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] r;
    csLow(); xfer(8'h02, r); xfer(a, r); xfer(d, r); csHigh();
  endtask

  task automatic rdTwo(input logic [7:0] a, output logic [7:0] d0, output logic [7:0] d1);
    logic [7:0] r;
    csLow(); xfer(8'h03, r); xfer(a, r); xfer(8'h00, d0); xfer(8'h00, d1); csHigh();
  endtask

  task automatic rdByte(input logic [7:0] a, output logic [7:0] d);
    logic [7:0] d1;
    rdTwo(a, d, d1);
  endtask

  initial begin
    waitClk(150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] st, d, d1, r;
    logic b;
    waitClk(5);
    rstN = 1'b1;
    waitClk(4);

    // R3, R5: reset state and standby
    check("R3 soEn idle", {31'd0, soEn}, 0);
    check("R3 so idle", {31'd0, so}, 0);
    rdsr(st);
    check("R5 status after reset", st, 8'h00);

    // R1, R4, R7: table of writes and read-backs
    for (int i = 0; i < NV; i++) begin
      cmd(8'h06);
      wrByte(VEC[i][15:8], VEC[i][7:0]);
      waitClk(WC + 20);
      rdByte(VEC[i][15:8], d);
      check("R1 R4 write/read table", d, {24'd0, VEC[i][7:0]});
    end

    // R6: write without write-enable
    wrByte(8'h05, 8'hAA);
    rdsr(st);
    check("R6 no cycle without enable", st, 8'h00);
    rdByte(8'h05, d);
    check("R6 memory unchanged", d, 8'h00);

    // R7, R8: busy window
    cmd(8'h06);
    wrByte(8'h06, 8'h5C);
    rdsr(st);
    check("R7 busy and enable during cycle", st, 8'h03);
    cmd(8'h06);
    wrByte(8'h07, 8'h11);
    waitClk(WC + 20);
    rdsr(st);
    check("R8 enable ignored while busy, R7 latch cleared", st, 8'h00);
    rdByte(8'h06, d);
    check("R7 data committed", d, 8'h5C);
    rdByte(8'h07, d);
    check("R8 write ignored while busy", d, 8'h00);

    // R12
    cmd(8'h06);
    rdsr(st);
    check("R12 latch set", st, 8'h02);
    cmd(8'h04);
    rdsr(st);
    check("R12 latch cleared", st, 8'h00);

    // R4: sequential read and wrap, high address bits ignored
    rdTwo(8'h00, d, d1);
    check("R4 seq first", d, 8'h3C);
    check("R4 seq second", d1, 8'hA5);
    rdTwo(8'hFF, d, d1);
    check("R4 wrap first", d, 8'h81);
    check("R4 wrap second", d1, 8'h3C);

    // R9: block protection
    cmd(8'h06); wrsr(8'h08); waitClk(WC + 20);
    rdsr(st);
    check("R5 bp field", st, 8'h08);
    cmd(8'h06); wrByte(8'h0C, 8'h77);
    rdsr(st);
    check("R9 blocked write keeps latch, no busy", st, 8'h0A);
    wrByte(8'h03, 8'h33); waitClk(WC + 20);
    rdByte(8'h0C, d);
    check("R9 top half blocked", d, 8'h00);
    rdByte(8'h03, d);
    check("R9 lower half written", d, 8'h33);
    cmd(8'h06); wrsr(8'h04); waitClk(WC + 20);
    cmd(8'h06); wrByte(8'h09, 8'h99); waitClk(WC + 20);
    cmd(8'h06); wrByte(8'h0D, 8'h66); waitClk(WC + 20);
    cmd(8'h04);
    rdByte(8'h09, d);
    check("R9 quarter allows 9", d, 8'h99);
    rdByte(8'h0D, d);
    check("R9 quarter blocks 13", d, 8'h00);

    // R10: hardware protection
    cmd(8'h06); wrsr(8'h84); waitClk(WC + 20);
    rdsr(st);
    check("R10 enable bit set", st, 8'h84);
    wpN = 1'b0;
    cmd(8'h06); wrsr(8'h00); waitClk(WC + 20);
    rdsr(st);
    check("R10 protected fields kept", st, 8'h84);
    wpN = 1'b1;
    cmd(8'h06); wrsr(8'h00); waitClk(WC + 20);
    rdsr(st);
    check("R10 fields writable with pin high", st, 8'h00);

    // R11: pause in the middle of the address byte
    csLow();
    xfer(8'h03, r);
    for (int i = 7; i >= 4; i--) xferBit(1'b0, b);
    sck = 1'b0; waitClk(4);
    holdN = 1'b0; waitClk(4);
    check("R11 soEn off while paused", {31'd0, soEn}, 0);
    for (int k = 0; k < 3; k++) begin
      si = 1'b1; sck = 1'b1; waitClk(4); sck = 1'b0; waitClk(4);
    end
    holdN = 1'b1; waitClk(4);
    check("R11 soEn back after pause", {31'd0, soEn}, 1);
    sck = 1'b0; si = 1'b1; waitClk(4); sck = 1'b1; waitClk(2);
    holdN = 1'b0; waitClk(4);
    check("R11 pause ignored while SCK high", {31'd0, soEn}, 1);
    holdN = 1'b1; waitClk(2);
    xferBit(1'b0, b); xferBit(1'b1, b); xferBit(1'b0, b);
    xfer(8'h00, d);
    csHigh();
    check("R11 read resumes intact", d, 8'h5A);

    // R2: mode 3 read
    mode3 = 1'b1;
    rdByte(8'h08, d);
    check("R2 mode 3 read", d, 8'hFF);
    rdsr(st);
    check("R2 mode 3 status", st, 8'h00);
    mode3 = 1'b0;

    // R3: abandoned frame
    csLow();
    xferBit(1'b1, b); xferBit(1'b1, b); xferBit(1'b0, b);
    csHigh();
    rdByte(8'h01, d);
    check("R3 restart after abort", d, 8'hA5);
    check("R3 soEn off after frame", {31'd0, soEn}, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule